// File: doc/BRIEF.md
# IR carrier generator

This block drives an infrared emitter with a carrier: a repeating high/low pattern whose high-time and low-time are programmed in ticks of a selectable modulation time base. One 32-bit count word sets both lengths. Each length is stored as its value minus one, so every field value is legal and the shortest period is two ticks. A duty cycle of d percent at a carrier period of N ticks is programmed as an on-length of round(N*d/100) and an off-length of the rest.

The tick source can be the system clock itself, a crystal enable divided by three inside the block, an external 1 µs tick or an external 10 µs tick. Software configures the block in a fixed order: clear the enable, pick the source and set the init-high flag, load the counts, clear init-high, then set the enable. Once the block runs, a new count word takes effect only at the next carrier-period boundary, so no period is ever cut short. A one-cycle strobe marks the last tick of every period. A downstream symbol sequencer can count these strobes as its time base.

Top module: `ir_carrier_gen`

## Requirements
- R1: The count word carries the on-length minus one in bits [31:16] and the off-length minus one in bits [15:0]. While running, the carrier is high for on+1 ticks and then low for off+1 ticks, and this repeats. Both fields may be zero, which gives a two-tick period.
- R2: Source code 0 makes every system clock cycle a tick.
- R3: Source code 1 makes one tick from every third pulse of the crystal enable. The divider is cleared while the block is not running, so the first tick after a start falls on the third crystal pulse.
- R4: Source code 2 ticks on the 1 µs tick input and code 3 ticks on the 10 µs tick input. Tick inputs that are not selected have no effect on the output.
- R5: While init-high is set, the carrier output is 1, no strobe occurs and the counters stay at zero. When init-high is cleared with the enable set, the pattern restarts at the first tick of the on-portion.
- R6: While the enable is clear, the carrier equals the init-high level and no strobe occurs. Ticks and count-word changes have no visible effect in this state.
- R7: A count word changed while the block runs takes effect only at the next period boundary. The block uses the word present in the strobe cycle, including a word that changes in that same cycle.
- R8: The end-of-period strobe is high for exactly the single system-clock cycle whose tick ends the off-portion. The carrier is low during that cycle and high again right after it.
- R9: During and directly after reset, with the enable and init-high inputs clear, the carrier and the strobe are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1us_i | input | 1 | One-cycle 1 µs tick enable |
| tick_10us_i | input | 1 | One-cycle 10 µs tick enable |
| xtal_en_i | input | 1 | One-cycle enable at the crystal rate |
| count_word_i | input | 32 | On-length minus one [31:16], off-length minus one [15:0] |
| en_i | input | 1 | Global run enable |
| init_high_i | input | 1 | Holds the output high and the counters at zero |
| src_sel_i | input | 2 | Tick source: 0 system clock, 1 crystal/3, 2 1 µs tick, 3 10 µs tick |
| carrier_o | output | 1 | Carrier level |
| period_end_o | output | 1 | Strobe on the last tick of each period |

## Verification
The end-of-period strobe and a count-word update can land in the same cycle. In that case the shadow copy must take the new word at the same edge that resets the phase counter. The bench provokes this by changing the word exactly in the strobe cycle of the first period. It then predicts the second period from the new lengths, and a second run changes the word mid-period to show that the old lengths finish first. Each cycle's carrier and strobe are compared with a tick-by-tick model, so an update taken one cycle early or late shows up as a wrong level.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_XTAL3 = 2'd1,
    SRC_US1   = 2'd2,
    SRC_US10  = 2'd3
  } tick_src_e;

  typedef enum logic {
    PH_ON  = 1'b0,
    PH_OFF = 1'b1
  } phase_e;

endpackage

// File: rtl/ir_tick_sel.sv
module ir_tick_sel
  import ir_carrier_pkg::*;
#(
  parameter int unsigned XTAL_DIV = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  tick_src_e src_i,
  input  logic      xtal_en_i,
  input  logic      tick_1us_i,
  input  logic      tick_10us_i,
  output logic      tick_o
);

  localparam int unsigned DIV_W = (XTAL_DIV > 2) ? $clog2(XTAL_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(XTAL_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             div_wrap;
  logic             xtal_tick;

  assign div_wrap  = (div_q == DIV_LAST);
  assign xtal_tick = xtal_en_i & div_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (clr_i) begin
      div_q <= '0;
    end else if (xtal_en_i) begin
      div_q <= div_wrap ? '0 : div_q + 1'b1;
    end
  end

  always_comb begin
    unique case (src_i)
      SRC_SYS:   tick_o = 1'b1;
      SRC_XTAL3: tick_o = xtal_tick;
      SRC_US1:   tick_o = tick_1us_i;
      SRC_US10:  tick_o = tick_10us_i;
      default:   tick_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ir_count_shadow.sv
module ir_count_shadow #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [2*CNT_W-1:0] word_i,
  output logic [CNT_W-1:0]   on_m1_o,
  output logic [CNT_W-1:0]   off_m1_o
);

  logic [2*CNT_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  assign on_m1_o  = word_q[2*CNT_W-1:CNT_W];
  assign off_m1_o = word_q[CNT_W-1:0];

endmodule

// File: rtl/ir_phase_ctr.sv
module ir_phase_ctr
  import ir_carrier_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] on_m1_i,
  input  logic [CNT_W-1:0] off_m1_i,
  output logic             on_o,
  output logic             last_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             on_done;
  logic             off_done;

  assign on_done  = (phase_q == PH_ON)  && (cnt_q == on_m1_i);
  assign off_done = (phase_q == PH_OFF) && (cnt_q == off_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ON;
      cnt_q   <= '0;
    end else if (!run_i) begin
      phase_q <= PH_ON;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (on_done) begin
        phase_q <= PH_OFF;
        cnt_q   <= '0;
      end else if (off_done) begin
        phase_q <= PH_ON;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign on_o   = (phase_q == PH_ON);
  assign last_o = run_i & tick_i & off_done;

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned XTAL_DIV = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_1us_i,
  input  logic               tick_10us_i,
  input  logic               xtal_en_i,
  input  logic [2*CNT_W-1:0] count_word_i,
  input  logic               en_i,
  input  logic               init_high_i,
  input  logic [1:0]         src_sel_i,
  output logic               carrier_o,
  output logic               period_end_o
);

  logic             run;
  logic             tick;
  logic             last;
  logic             phase_on;
  logic [CNT_W-1:0] on_m1;
  logic [CNT_W-1:0] off_m1;

  assign run = en_i & ~init_high_i;

  ir_tick_sel #(
    .XTAL_DIV (XTAL_DIV)
  ) u_tick_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (~run),
    .src_i       (tick_src_e'(src_sel_i)),
    .xtal_en_i   (xtal_en_i),
    .tick_1us_i  (tick_1us_i),
    .tick_10us_i (tick_10us_i),
    .tick_o      (tick)
  );

  // shadow follows the word while idle, then only at period boundaries
  ir_count_shadow #(
    .CNT_W (CNT_W)
  ) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (~run | last),
    .word_i   (count_word_i),
    .on_m1_o  (on_m1),
    .off_m1_o (off_m1)
  );

  ir_phase_ctr #(
    .CNT_W (CNT_W)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .tick_i   (tick),
    .on_m1_i  (on_m1),
    .off_m1_i (off_m1),
    .on_o     (phase_on),
    .last_o   (last)
  );

  assign carrier_o    = run ? phase_on : init_high_i;
  assign period_end_o = last;

endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic init_high_i,
  input logic carrier_o,
  input logic period_end_o
);

  p_strobe_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |-> !carrier_o);

  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> !period_end_o);

  p_boundary_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> (carrier_o || !en_i || init_high_i));

  p_restart_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(init_high_i) && !init_high_i) |-> carrier_o);

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> (carrier_o == init_high_i && !period_end_o));

  p_init_no_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_high_i && $past(init_high_i)) |-> (carrier_o && !period_end_o));

endmodule

bind ir_carrier_gen ir_carrier_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .init_high_i  (init_high_i),
  .carrier_o    (carrier_o),
  .period_end_o (period_end_o)
);

// File: tb/ir_carrier_gen_tb.sv
`timescale 1ns/1ps
module ir_carrier_gen_tb;

  typedef struct {
    bit    c;
    bit    s;
    string req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_1us_i = 1'b0;
  logic        tick_10us_i = 1'b0;
  logic        xtal_en_i = 1'b0;
  logic [31:0] count_word_i = '0;
  logic        en_i = 1'b0;
  logic        init_high_i = 1'b0;
  logic [1:0]  src_sel_i = 2'd0;
  logic        carrier_o;
  logic        period_end_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  int gc = 0;
  int pos = 0;
  int act_on = 0;
  int act_off = 0;
  int xc = 0;

  always #2.5 clk_i = ~clk_i;

  ir_carrier_gen u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_1us_i   (tick_1us_i),
    .tick_10us_i  (tick_10us_i),
    .xtal_en_i    (xtal_en_i),
    .count_word_i (count_word_i),
    .en_i         (en_i),
    .init_high_i  (init_high_i),
    .src_sel_i    (src_sel_i),
    .carrier_o    (carrier_o),
    .period_end_o (period_end_o)
  );

  task automatic drive_ticks();
    tick_1us_i  = (gc % 4 == 0);
    tick_10us_i = (gc % 7 == 3);
    xtal_en_i   = (gc % 2 == 0);
  endtask

  task automatic push(input bit c, input bit s, input string req);
    exp_t e;
    e.c = c;
    e.s = s;
    e.req = req;
    q.push_back(e);
  endtask

  // not running for n cycles: output is the init level, shadow tracks w
  task automatic hold(input bit e, input bit ih, input logic [31:0] w,
                      input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      en_i = e;
      init_high_i = ih;
      count_word_i = w + ((i == n - 1) ? 32'd0 : 32'(i * 32'h0001_0003));
      drive_ticks();
      push(ih, 1'b0, req);
      gc++;
    end
    @(negedge clk_i);
    en_i = e;
    init_high_i = ih;
    count_word_i = w;
    drive_ticks();
    push(ih, 1'b0, req);
    gc++;
    act_on = int'(w[31:16]);
    act_off = int'(w[15:0]);
    pos = 0;
    xc = 0;
  endtask

  task automatic run(input logic [1:0] sel, input logic [31:0] w0,
                     input logic [31:0] w1, input int chg, input int n,
                     input string req);
    for (int i = 0; i < n; i++) begin
      int  p;
      bit  t;
      bit  es;
      logic [31:0] w;
      @(negedge clk_i);
      w = (i >= chg) ? w1 : w0;
      en_i = 1'b1;
      init_high_i = 1'b0;
      src_sel_i = sel;
      count_word_i = w;
      drive_ticks();
      case (sel)
        2'd0: t = 1'b1;
        2'd1: t = xtal_en_i && (xc == 2);
        2'd2: t = tick_1us_i;
        default: t = tick_10us_i;
      endcase
      p = act_on + act_off + 2;
      es = t && (pos == p - 1);
      push(pos < act_on + 1, es, req);
      if (sel == 2'd1 && xtal_en_i) xc = (xc + 1) % 3;
      if (es) begin
        pos = 0;
        act_on = int'(w[31:16]);
        act_off = int'(w[15:0]);
      end else if (t) begin
        pos++;
      end
      gc++;
    end
  endtask

  task automatic seq(input logic [1:0] sel, input logic [31:0] w0,
                     input logic [31:0] w1, input int chg, input int n,
                     input string req);
    @(negedge clk_i);
    src_sel_i = sel;
    hold(1'b0, 1'b0, w0, 2, req);
    run(sel, w0, w1, chg, n, req);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (carrier_o !== e.c || period_end_o !== e.s) begin
          errors++;
          $display("FAIL %s: carrier/strobe actual %b/%b expected %b/%b at %0t",
                   e.req, carrier_o, period_end_o, e.c, e.s, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    checks++;
    if (carrier_o !== 1'b0 || period_end_o !== 1'b0) begin
      errors++;
      $display("FAIL R9: reset carrier/strobe actual %b/%b expected 0/0",
               carrier_o, period_end_o);
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    hold(1'b0, 1'b0, 32'h0002_0004, 3, "R9");

    // R6: idle with ticks and word changes present
    hold(1'b0, 1'b0, 32'h0001_0001, 8, "R6");
    hold(1'b0, 1'b1, 32'h0001_0001, 6, "R6");

    // R1 / R2: system clock ticks
    seq(2'd0, 32'h0002_0004, 32'h0002_0004, 1000, 30, "R1");
    seq(2'd0, 32'h0000_0000, 32'h0000_0000, 1000, 12, "R1");
    seq(2'd0, 32'h0005_0000, 32'h0005_0000, 1000, 20, "R2");
    seq(2'd0, 32'h0000_0003, 32'h0000_0003, 1000, 20, "R8");

    // R5: init-high then release
    hold(1'b1, 1'b1, 32'h0001_0000, 6, "R5");
    run(2'd0, 32'h0001_0000, 32'h0001_0000, 1000, 12, "R5");

    // R7: change in the strobe cycle, and mid-period
    seq(2'd0, 32'h0002_0004, 32'h0003_0001, 7, 30, "R7");
    seq(2'd0, 32'h0002_0004, 32'h0000_0002, 12, 30, "R7");

    // R3 / R4: divided and external ticks
    seq(2'd1, 32'h0003_0002, 32'h0003_0002, 1000, 80, "R3");
    seq(2'd2, 32'h0001_0001, 32'h0001_0001, 1000, 60, "R4");
    seq(2'd3, 32'h0000_0002, 32'h0000_0002, 1000, 80, "R4");

    // R6: disable mid-run
    hold(1'b0, 1'b0, 32'h0002_0002, 5, "R6");

    wait (q.size() == 0);
    @(negedge clk_i);
    #2;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule